// File: doc/BRIEF.md
# UART Interrupt Identifier

This block merges the four interrupt causes of a UART into one active-high interrupt line and an 8-bit identification byte that the CPU reads. The four causes are line errors, a newly received character, an empty transmit holding register, and changes on the modem inputs. Only the most urgent pending cause is shown in the byte. A lower cause stays hidden until every higher one has been serviced. Each cause has its own enable bit and its own way of being cleared. The clears come from strobes that the bus decoder raises when the CPU reads the line status, receive buffer, modem status or identification register, or writes the transmit holding register.

The line-error, received-data and modem causes are event latches. Each latch is set by a one-cycle event pulse and cleared by its read strobe. The holding-empty cause is a two-state machine. In state `THRE_QUIET` no request is raised. In state `THRE_PEND` a request is raised. The transition *arm* (QUIET to PEND) happens on a rising edge of the holding-empty level, or when its enable turns on while the register is already empty. The transition *service* (PEND to QUIET) happens on a holding-register write, on an identification read while holding-empty is the reported cause, or when its enable is turned off.

Pending flags update on the clock edge that samples an event or strobe. The identification byte and the interrupt line follow those flags, and the enables, without further delay.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01 and `irq` is low.
- R2: Bits 7 to 3 of the identification byte always read zero. Bit 0 is 0 when some enabled cause is pending and 1 when none is.
- R3: Bits 2:1 show the highest pending cause. The codes are 11 for line error, 10 for received data, 01 for holding empty and 00 for modem change, and that list is the priority order from highest to lowest. The full byte values are therefore 0x06, 0x04, 0x02 and 0x00.
- R4: Any bit of `line_err` sets the line-error cause. A `rd_lsr` strobe clears it, and a `rd_iir` strobe leaves it unchanged.
- R5: A `rx_done` pulse sets the received-data cause, and a `rd_rbr` strobe clears it.
- R6: Any bit of `modem_delta` sets the modem cause, and a `rd_msr` strobe clears it.
- R7: A rising edge of `thr_empty` while enabled raises the holding-empty cause. A steady high level does not raise it again. A `wr_thr` strobe clears it.
- R8: A `rd_iir` strobe clears the holding-empty cause only when the byte being read shows code 01. When a higher cause is shown, the holding-empty cause survives the read.
- R9: Turning on the holding-empty enable while `thr_empty` is already high raises the holding-empty cause.
- R10: The enable bits are `src_en[0]` for received data, `[1]` for holding empty, `[2]` for line error and `[3]` for modem. A disabled cause never becomes pending and never shows in the byte. Turning its enable off discards any pending request for that cause.
- R11: `irq` is high exactly when bit 0 of the identification byte is low.
- R12: When a set event and the clearing strobe for the same cause arrive in the same cycle, the set wins and the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_err | input | 4 | Event pulses for overrun, parity, framing and break |
| rx_done | input | 1 | Event pulse: a character has arrived in the receive buffer |
| thr_empty | input | 1 | Level: transmit holding register is empty |
| modem_delta | input | 4 | Event pulses for changes on CTS, DSR, RI and DCD |
| src_en | input | 4 | Enable bits per cause (see R10) |
| rd_lsr | input | 1 | Strobe: CPU reads the line status register |
| rd_rbr | input | 1 | Strobe: CPU reads the receive buffer |
| rd_iir | input | 1 | Strobe: CPU reads the identification byte |
| rd_msr | input | 1 | Strobe: CPU reads the modem status register |
| wr_thr | input | 1 | Strobe: CPU writes the transmit holding register |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
A latch left set or cleared wrongly shows in the identification byte on the first cycle in which no higher cause masks it. For that reason the stimulus services causes one at a time, from the top of the priority order down, so that each lower cause gets its turn at the ports. A holding-empty machine stuck in the wrong state shows within one cycle of an arm or service event. The cases that tell a correct design from a faulty one are an identification read while a higher cause is shown, and a steady holding-empty level. Wrong priority or a wrong enable mask changes the byte in the same cycle the inputs change.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    // Cause codes as they appear in identification bits 2:1
    typedef enum logic [1:0] {
        SRC_MODEM  = 2'b00,
        SRC_THRE   = 2'b01,
        SRC_RXDATA = 2'b10,
        SRC_LINE   = 2'b11
    } src_code_t;

    typedef enum logic {
        THRE_QUIET = 1'b0,
        THRE_PEND  = 1'b1
    } thre_state_t;

    // Index of each cause in the enable and request vectors
    localparam int EN_RXD   = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int NSRC     = 4;
endpackage

// File: rtl/uirq_evt_latch.sv
module uirq_evt_latch #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic         pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (!en)
            pend <= 1'b0;
        else if (|evt)
            pend <= 1'b1;   // set wins over a same-cycle clear
        else if (clr)
            pend <= 1'b0;
    end
endmodule

// File: rtl/uirq_thre_fsm.sv
module uirq_thre_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic thr_empty,
    input  logic wr_thr,
    input  logic rd_iir,
    input  logic shown,
    output logic pend
);
    thre_state_t state, nxt;
    logic        thr_q, en_q;
    logic        arm, service;

    assign arm     = en && thr_empty && (!thr_q || !en_q);
    assign service = !en || wr_thr || (rd_iir && shown);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= THRE_QUIET;
            thr_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            state <= nxt;
            thr_q <= thr_empty;
            en_q  <= en;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            THRE_QUIET: if (arm)     nxt = THRE_PEND;
            THRE_PEND:  if (service) nxt = THRE_QUIET;
            default:                 nxt = THRE_QUIET;
        endcase
    end

    always_comb begin
        pend = (state == THRE_PEND);
    end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
#(
    parameter int IDW = 8
) (
    input  logic [NSRC-1:0] req,
    output logic [IDW-1:0]  ident
);
    always_comb begin
        ident    = '0;
        ident[0] = 1'b1;
        if (req[EN_LINE]) begin
            ident[2:1] = SRC_LINE;
            ident[0]   = 1'b0;
        end else if (req[EN_RXD]) begin
            ident[2:1] = SRC_RXDATA;
            ident[0]   = 1'b0;
        end else if (req[EN_THRE]) begin
            ident[2:1] = SRC_THRE;
            ident[0]   = 1'b0;
        end else if (req[EN_MODEM]) begin
            ident[2:1] = SRC_MODEM;
            ident[0]   = 1'b0;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int LS_W = 4,
    parameter int MD_W = 4,
    parameter int IDW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LS_W-1:0] line_err,
    input  logic            rx_done,
    input  logic            thr_empty,
    input  logic [MD_W-1:0] modem_delta,
    input  logic [NSRC-1:0] src_en,
    input  logic            rd_lsr,
    input  logic            rd_rbr,
    input  logic            rd_iir,
    input  logic            rd_msr,
    input  logic            wr_thr,
    output logic [IDW-1:0]  ident,
    output logic            irq
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] req;
    logic            thre_shown;

    uirq_evt_latch #(.W(LS_W)) u_line (
        .clk(clk), .rst_n(rst_n), .en(src_en[EN_LINE]),
        .evt(line_err), .clr(rd_lsr), .pend(pend[EN_LINE])
    );

    uirq_evt_latch #(.W(1)) u_rxd (
        .clk(clk), .rst_n(rst_n), .en(src_en[EN_RXD]),
        .evt(rx_done), .clr(rd_rbr), .pend(pend[EN_RXD])
    );

    uirq_evt_latch #(.W(MD_W)) u_modem (
        .clk(clk), .rst_n(rst_n), .en(src_en[EN_MODEM]),
        .evt(modem_delta), .clr(rd_msr), .pend(pend[EN_MODEM])
    );

    uirq_thre_fsm u_thre (
        .clk(clk), .rst_n(rst_n), .en(src_en[EN_THRE]),
        .thr_empty(thr_empty), .wr_thr(wr_thr), .rd_iir(rd_iir),
        .shown(thre_shown), .pend(pend[EN_THRE])
    );

    assign req = pend & src_en;

    uirq_prio_enc #(.IDW(IDW)) u_enc (
        .req(req), .ident(ident)
    );

    assign thre_shown = !ident[0] && (ident[2:1] == SRC_THRE);
    assign irq        = |req;
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
    parameter int LS_W = 4,
    parameter int IDW  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [LS_W-1:0] line_err,
    input logic [3:0]      src_en,
    input logic            rd_lsr,
    input logic            rd_iir,
    input logic            wr_thr,
    input logic [IDW-1:0]  ident,
    input logic            irq
);
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ident[IDW-1:3] == '0);

    a_r11_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !ident[0]);

    a_r4_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && line_err == '0) |=> !(ident[0] == 1'b0 && ident[2:1] == 2'b11));

    a_r3_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_err && src_en[2]) |=> (ident[2:0] == 3'b110 || !src_en[2]));

    a_r10_line_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en[2] |-> ident[2:0] != 3'b110);

    a_r10_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == 4'b0) |-> !irq);

    a_r7_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && ident[2:0] == 3'b010) |=> ident[2:0] != 3'b010);

    a_r8_iir_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && ident[2:0] == 3'b010) |=> ident[2:0] != 3'b010);
endmodule

bind uart_irq_ident uirq_checker #(.LS_W(LS_W), .IDW(IDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_err(line_err), .src_en(src_en),
    .rd_lsr(rd_lsr), .rd_iir(rd_iir), .wr_thr(wr_thr),
    .ident(ident), .irq(irq)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] line_err = '0;
    logic       rx_done = 1'b0;
    logic       thr_empty = 1'b0;
    logic [3:0] modem_delta = '0;
    logic [3:0] src_en = '0;
    logic       rd_lsr = 1'b0, rd_rbr = 1'b0, rd_iir = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
    logic [7:0] ident;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_done(rx_done),
        .thr_empty(thr_empty), .modem_delta(modem_delta), .src_en(src_en),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir), .rd_msr(rd_msr),
        .wr_thr(wr_thr), .ident(ident), .irq(irq)
    );

    // Driver: one call is one clock cycle of stimulus plus its expected byte
    task automatic cyc(input logic [3:0] le, input logic rx, input logic te,
                       input logic [3:0] md, input logic [3:0] en,
                       input logic rl, input logic rr, input logic ri,
                       input logic rm, input logic wt,
                       input logic [7:0] exp, input string tag);
        @(negedge clk);
        line_err = le; rx_done = rx; thr_empty = te; modem_delta = md;
        src_en = en; rd_lsr = rl; rd_rbr = rr; rd_iir = ri; rd_msr = rm; wr_thr = wt;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after the edge that samples each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (ident !== e) begin
                    fails++;
                    $display("FAIL %s ident actual=%h expected=%h", t, ident, e);
                end
                checks++;
                if (irq !== !e[0]) begin
                    fails++;
                    $display("FAIL R11 irq actual=%b expected=%b", irq, !e[0]);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (ident !== 8'h01 || irq !== 1'b0) begin
            fails++;
            $display("FAIL R1 actual=%h/%b expected=01/0", ident, irq);
        end
        rst_n = 1'b1;
        //   le    rx  te  md    en    rl rr ri rm wt  exp
        cyc(4'h0, 0, 0, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h01, "R1");
        cyc(4'h0, 1, 0, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h04, "R5");
        cyc(4'h0, 0, 0, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h04, "R5");
        cyc(4'h0, 0, 0, 4'h1, 4'hF, 0, 0, 0, 0, 0, 8'h04, "R3");
        cyc(4'h2, 0, 0, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h06, "R3");
        cyc(4'h0, 0, 0, 4'h0, 4'hF, 0, 0, 1, 0, 0, 8'h06, "R4");
        cyc(4'h0, 0, 0, 4'h0, 4'hF, 1, 0, 0, 0, 0, 8'h04, "R4");
        cyc(4'h0, 0, 0, 4'h0, 4'hF, 0, 1, 0, 0, 0, 8'h00, "R5");
        cyc(4'h0, 0, 0, 4'h0, 4'hF, 0, 0, 0, 1, 0, 8'h01, "R6");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h02, "R7");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 0, 0, 1, 0, 0, 8'h01, "R8");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h01, "R7");
        cyc(4'h0, 0, 0, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h01, "R7");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h02, "R7");
        cyc(4'h1, 0, 1, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h06, "R3");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 0, 0, 1, 0, 0, 8'h06, "R8");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 1, 0, 0, 0, 0, 8'h02, "R8");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 0, 0, 0, 0, 1, 8'h01, "R7");
        cyc(4'h0, 0, 1, 4'h0, 4'hD, 0, 0, 0, 0, 0, 8'h01, "R9");
        cyc(4'h0, 0, 1, 4'h0, 4'hF, 0, 0, 0, 0, 0, 8'h02, "R9");
        cyc(4'h0, 0, 1, 4'h0, 4'hD, 0, 0, 0, 0, 0, 8'h01, "R10");
        cyc(4'h0, 1, 1, 4'h0, 4'h0, 0, 0, 0, 0, 0, 8'h01, "R10");
        cyc(4'h0, 0, 1, 4'h0, 4'h1, 0, 0, 0, 0, 0, 8'h01, "R10");
        cyc(4'h0, 1, 1, 4'h0, 4'h1, 0, 1, 0, 0, 0, 8'h04, "R12");
        cyc(4'h0, 0, 1, 4'h0, 4'h1, 0, 1, 0, 0, 0, 8'h01, "R5");
        cyc(4'h0, 0, 1, 4'h4, 4'h8, 0, 0, 0, 0, 0, 8'h00, "R6");
        cyc(4'h0, 0, 1, 4'h8, 4'h8, 0, 0, 0, 1, 0, 8'h00, "R12");
        cyc(4'h0, 0, 1, 4'h0, 4'h8, 0, 0, 0, 1, 0, 8'h01, "R6");
        cyc(4'h0, 0, 1, 4'h0, 4'h8, 0, 0, 0, 0, 0, 8'h01, "R2");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule